// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block prepares a raw asynchronous NAND flash device for a page read. A request carries a block number, a page within that block, a column offset, a flag that asks for the spare area instead of the main data area, and a flag for a 16-bit device bus. The block turns the request into a string of command-latch and address-latch cycles. It drives the command-latch enable, the address-latch enable, the active-low write strobe and the 8-bit IO bus. It waits on the device's ready line before the first latch cycle and again after the last one.

Two parameters fix the device geometry at build time. One selects small-page or large-page addressing. The other adds a final row-address cycle for large parts. On large-page parts a spare-area read becomes a normal read whose column is pushed past the page data. When the ready line stays busy for too long, the sequence ends with an error flag instead of a completion pulse. Moving data after the sequence, and ECC, belong to other logic.

Top module: `nand_read_seq`

## Requirements
- R1: The row address equals page + block × PAGES_PER_BLOCK. Its row bytes go out least significant byte first.
- R2: No write strobe falls while the ready line reports busy after a request. After the last latch cycle, `done` stays low until ready returns. `done` is then a single-cycle pulse in which `busy` is already low.
- R3: Each latch cycle holds `nand_we_n` low for exactly WE_LOW_CLKS clocks. It then holds it high for one clock, and CLE, ALE and IO do not change across the whole cycle. A command cycle has CLE=1, ALE=0 and an address cycle has ALE=1, CLE=0; both are never high together.
- R4: Large-page order: command 0x00 on CLE, column low byte, column high byte, row byte 0, row byte 1, then the confirm command 0x30 on CLE.
- R5: With EXTRA_CYCLE=1 an extra address byte follows row byte 1. It carries row bits [19:16] in bits [3:0], and its bits [7:4] are zero.
- R6: In large-page mode a spare request sends opcode 0x00, and the column sent is the requested column plus PAGE_BYTES.
- R7: In large-page mode with `bus16`=1 the column, after the spare adjustment, is shifted right by one bit before it is sent.
- R8: Small-page order: command (0x00 for main, 0x50 for spare), one column byte (column bits [7:0]), row byte 0, row byte 1, and the extra row byte only when EXTRA_CYCLE=1. No confirm is sent, and `bus16` has no effect.
- R9: If the ready line stays busy for TIMEOUT_CYCLES consecutive clocks in either wait, `timeout_err` rises, `busy` falls, and no `done` pulse and no further latch cycle occur. `timeout_err` clears when the next request is accepted.
- R10: A request asserted while `busy` is high is ignored: the bytes sent are those of the request already under way.
- R11: After reset `busy`, `done`, `timeout_err`, `nand_cle`, `nand_ale` and `nand_io` are 0, and `nand_we_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a read setup (taken only when idle) |
| req_block | input | BLOCK_W | Erase-block number |
| req_page | input | PAGE_W | Page within the block |
| req_col | input | COL_W | Byte column within the page |
| req_spare | input | 1 | Read the spare area instead of the main area |
| bus16 | input | 1 | Device has a 16-bit data bus |
| rb_ready | input | 1 | Device ready line, 1 = ready |
| nand_cle | output | 1 | Command-latch enable |
| nand_ale | output | 1 | Address-latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | Command/address byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: device ready with the page |
| timeout_err | output | 1 | Ready wait expired |

## Verification
The bench targets the geometry corners. The first is a row above 16 bits, where a design that dropped the top nibble, or left the high nibble unmasked, would send a wrong extra byte. The second is spare reads in both modes, where a large-page design that kept 0x50, or forgot the page-size offset, would address the wrong column. The third is a 16-bit bus, where shifting before the spare offset, or shifting in small-page mode, gives a different column byte. It also holds the ready line busy before and after the latch cycles, and past the timeout in each wait. A design that latched early, pulsed `done` too soon, or kept driving after expiry would show stray strobes or a missing or extra `done` or error flag. A second request sent mid-sequence would corrupt the captured bytes in a design that did not ignore it.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

  localparam int NRS_MAX_ITEMS = 7;

  localparam logic [7:0] OPC_READ        = 8'h00;
  localparam logic [7:0] OPC_SPARE_SMALL = 8'h50;
  localparam logic [7:0] OPC_CONFIRM     = 8'h30;

  typedef struct packed {
    logic       is_cmd;
    logic [7:0] val;
  } nrs_item_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOW,
    ST_HIGH,
    ST_POST
  } nrs_state_t;

endpackage

// File: rtl/nrs_addr_build.sv
module nrs_addr_build
  import nrs_pkg::*;
#(
  parameter bit LARGE_PAGE      = 1'b1,
  parameter bit EXTRA_CYCLE     = 1'b0,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int BLOCK_W         = 12,
  parameter int PAGE_W          = 6,
  parameter int COL_W           = 11
) (
  input  logic [BLOCK_W-1:0] blk,
  input  logic [PAGE_W-1:0]  pg,
  input  logic [COL_W-1:0]   col,
  input  logic               spare,
  input  logic               bus16,
  output nrs_item_t          items [NRS_MAX_ITEMS],
  output logic [2:0]         count
);

  localparam int ROW_W = 24;

  logic [ROW_W-1:0] row;
  logic             unused_bits;

  always_comb row = ROW_W'(pg) + ROW_W'(blk) * ROW_W'(PAGES_PER_BLOCK);

  assign unused_bits = ^{row, bus16, col, spare};

  generate
    if (LARGE_PAGE) begin : g_large
      logic [15:0] c_adj;
      logic [15:0] c_word;
      always_comb begin
        c_adj  = 16'(col) + (spare ? 16'(PAGE_BYTES) : 16'd0);
        c_word = bus16 ? (c_adj >> 1) : c_adj;
        for (int k = 0; k < NRS_MAX_ITEMS; k++) items[k] = '0;
        items[0] = '{is_cmd: 1'b1, val: OPC_READ};
        items[1] = '{is_cmd: 1'b0, val: c_word[7:0]};
        items[2] = '{is_cmd: 1'b0, val: c_word[15:8]};
        items[3] = '{is_cmd: 1'b0, val: row[7:0]};
        items[4] = '{is_cmd: 1'b0, val: row[15:8]};
        if (EXTRA_CYCLE) begin
          items[5] = '{is_cmd: 1'b0, val: {4'h0, row[19:16]}};
          items[6] = '{is_cmd: 1'b1, val: OPC_CONFIRM};
          count    = 3'd7;
        end else begin
          items[5] = '{is_cmd: 1'b1, val: OPC_CONFIRM};
          count    = 3'd6;
        end
      end
    end else begin : g_small
      always_comb begin
        for (int k = 0; k < NRS_MAX_ITEMS; k++) items[k] = '0;
        items[0] = '{is_cmd: 1'b1, val: spare ? OPC_SPARE_SMALL : OPC_READ};
        items[1] = '{is_cmd: 1'b0, val: 8'(col)};
        items[2] = '{is_cmd: 1'b0, val: row[7:0]};
        items[3] = '{is_cmd: 1'b0, val: row[15:8]};
        if (EXTRA_CYCLE) begin
          items[4] = '{is_cmd: 1'b0, val: {4'h0, row[19:16]}};
          count    = 3'd5;
        end else begin
          count    = 3'd4;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/nrs_phase_cnt.sv
module nrs_phase_cnt #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

endmodule

// File: rtl/nrs_rb_watch.sv
module nrs_rb_watch #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic ready,
  output logic expired
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = arm && !ready && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !arm || ready) cnt <= '0;
    else if (!expired)        cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
  import nrs_pkg::*;
#(
  parameter bit LARGE_PAGE      = 1'b1,
  parameter bit EXTRA_CYCLE     = 1'b0,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int BLOCK_W         = 12,
  parameter int WE_LOW_CLKS     = 2,
  parameter int TIMEOUT_CYCLES  = 4096,
  localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK),
  localparam int COL_W          = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [BLOCK_W-1:0] req_block,
  input  logic [PAGE_W-1:0]  req_page,
  input  logic [COL_W-1:0]   req_col,
  input  logic               req_spare,
  input  logic               bus16,
  input  logic               rb_ready,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic [7:0]         nand_io,
  output logic               busy,
  output logic               done,
  output logic               timeout_err
);

  localparam int WE_W = $clog2(WE_LOW_CLKS + 1);

  nrs_state_t  state;
  nrs_item_t   items_w [NRS_MAX_ITEMS];
  logic [2:0]  count_w;
  nrs_item_t   seq_q [NRS_MAX_ITEMS];
  logic [2:0]  n_q;
  logic [2:0]  idx_q;
  logic [2:0]  nxt_idx;
  nrs_item_t   nxt_item;
  logic [WE_W-1:0] we_cnt;
  logic        we_last;
  logic        wait_arm;
  logic        expired;

  nrs_addr_build #(
    .LARGE_PAGE      (LARGE_PAGE),
    .EXTRA_CYCLE     (EXTRA_CYCLE),
    .PAGE_BYTES      (PAGE_BYTES),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .BLOCK_W         (BLOCK_W),
    .PAGE_W          (PAGE_W),
    .COL_W           (COL_W)
  ) u_build (
    .blk   (req_block),
    .pg    (req_page),
    .col   (req_col),
    .spare (req_spare),
    .bus16 (bus16),
    .items (items_w),
    .count (count_w)
  );

  nrs_phase_cnt #(.WIDTH(WE_W)) u_we_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (state != ST_LOW),
    .inc   (state == ST_LOW),
    .count (we_cnt)
  );

  assign we_last  = (we_cnt == WE_W'(WE_LOW_CLKS - 1));
  assign wait_arm = (state == ST_PRE) || (state == ST_POST);

  nrs_rb_watch #(.LIMIT(TIMEOUT_CYCLES)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .arm     (wait_arm),
    .ready   (rb_ready),
    .expired (expired)
  );

  assign nxt_idx  = idx_q + 3'd1;
  assign nxt_item = seq_q[nxt_idx];

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      state       <= ST_IDLE;
      n_q         <= '0;
      idx_q       <= '0;
      busy        <= 1'b0;
      timeout_err <= 1'b0;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_we_n   <= 1'b1;
      nand_io     <= '0;
      for (int k = 0; k < NRS_MAX_ITEMS; k++) seq_q[k] <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            for (int k = 0; k < NRS_MAX_ITEMS; k++) seq_q[k] <= items_w[k];
            n_q         <= count_w;
            idx_q       <= '0;
            busy        <= 1'b1;
            timeout_err <= 1'b0;
            state       <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (rb_ready) begin
            nand_cle  <= seq_q[0].is_cmd;
            nand_ale  <= !seq_q[0].is_cmd;
            nand_io   <= seq_q[0].val;
            nand_we_n <= 1'b0;
            state     <= ST_LOW;
          end else if (expired) begin
            timeout_err <= 1'b1;
            busy        <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        ST_LOW: begin
          if (we_last) begin
            nand_we_n <= 1'b1;
            state     <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (idx_q == n_q - 3'd1) begin
            nand_cle <= 1'b0;
            nand_ale <= 1'b0;
            state    <= ST_POST;
          end else begin
            idx_q     <= nxt_idx;
            nand_cle  <= nxt_item.is_cmd;
            nand_ale  <= !nxt_item.is_cmd;
            nand_io   <= nxt_item.val;
            nand_we_n <= 1'b0;
            state     <= ST_LOW;
          end
        end
        ST_POST: begin
          if (rb_ready) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (expired) begin
            timeout_err <= 1'b1;
            busy        <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nrs_checker.sv
module nrs_checker (
  input logic       clk,
  input logic       rst,
  input logic       rb_ready,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic [7:0] nand_io,
  input logic       busy,
  input logic       done,
  input logic       timeout_err
);

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale)); // R3

  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_io))); // R3

  AST_WE_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && !$past(nand_we_n)) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_io))); // R3

  AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rb_ready)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> nand_we_n); // R9

  AST_ERR_EXCL_DONE: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout_err)); // R9

endmodule

bind nand_read_seq nrs_checker u_nrs_checker (
  .clk         (clk),
  .rst         (rst),
  .rb_ready    (rb_ready),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_io     (nand_io),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err)
);

// File: tb/test_nand_read_seq.sv
module latch_mon #(
  parameter int WE_LOW = 2
) (
  input logic       clk,
  input logic       clr,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic [7:0] io
);
  logic [7:0] cap_b [16];
  logic       cap_c [16];
  logic       cap_a [16];
  int n_cap = 0;
  int n_bad = 0;
  int low_cnt = 0;
  logic prev_we = 1'b1;
  logic s_cle = 1'b0, s_ale = 1'b0;
  logic [7:0] s_io = 8'h00;

  always @(negedge clk) begin
    if (clr) begin
      n_cap = 0;
      n_bad = 0;
      low_cnt = 0;
    end else begin
      if (cle && ale) n_bad++;
      if (!we_n) begin
        if (prev_we) begin
          low_cnt = 1; s_cle = cle; s_ale = ale; s_io = io;
        end else begin
          low_cnt++;
          if (cle != s_cle || ale != s_ale || io != s_io) n_bad++;
        end
      end else if (!prev_we) begin
        if (low_cnt != WE_LOW) n_bad++;
        if (cle != s_cle || ale != s_ale || io != s_io) n_bad++;
        if (n_cap < 16) begin
          cap_b[n_cap] = s_io; cap_c[n_cap] = s_cle; cap_a[n_cap] = s_ale;
        end
        n_cap++;
      end
    end
    prev_we = we_n;
  end
endmodule

module test_nand_read_seq;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid_l = 0, req_valid_s = 0;
  logic [11:0] req_block = '0;
  logic [5:0]  req_page = '0;
  logic [10:0] req_col = '0;
  logic        req_spare = 0, bus16 = 0;
  logic        rb_l = 1, rb_s = 1;
  logic        clr_l = 0, clr_s = 0;

  logic cle_l, ale_l, we_l, busy_l, done_l, err_l;
  logic cle_s, ale_s, we_s, busy_s, done_s, err_s;
  logic [7:0] io_l, io_s;

  nand_read_seq #(
    .LARGE_PAGE(1'b1), .EXTRA_CYCLE(1'b1), .PAGE_BYTES(2048), .PAGES_PER_BLOCK(64),
    .BLOCK_W(12), .WE_LOW_CLKS(3), .TIMEOUT_CYCLES(TMO)
  ) i_nand_read_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid_l), .req_block(req_block),
    .req_page(req_page), .req_col(req_col), .req_spare(req_spare), .bus16(bus16),
    .rb_ready(rb_l), .nand_cle(cle_l), .nand_ale(ale_l), .nand_we_n(we_l),
    .nand_io(io_l), .busy(busy_l), .done(done_l), .timeout_err(err_l)
  );

  nand_read_seq #(
    .LARGE_PAGE(1'b0), .EXTRA_CYCLE(1'b0), .PAGE_BYTES(512), .PAGES_PER_BLOCK(32),
    .BLOCK_W(12), .WE_LOW_CLKS(2), .TIMEOUT_CYCLES(TMO)
  ) i_nand_read_seq_sp (
    .clk(clk), .rst(rst), .req_valid(req_valid_s), .req_block(req_block),
    .req_page(req_page[4:0]), .req_col(req_col[8:0]), .req_spare(req_spare), .bus16(bus16),
    .rb_ready(rb_s), .nand_cle(cle_s), .nand_ale(ale_s), .nand_we_n(we_s),
    .nand_io(io_s), .busy(busy_s), .done(done_s), .timeout_err(err_s)
  );

  latch_mon #(.WE_LOW(3)) mon_l (.clk(clk), .clr(clr_l), .cle(cle_l), .ale(ale_l), .we_n(we_l), .io(io_l));
  latch_mon #(.WE_LOW(2)) mon_s (.clk(clk), .clr(clr_s), .cle(cle_s), .ale(ale_s), .we_n(we_s), .io(io_s));

  int checks = 0;
  int errors = 0;
  int dcnt_l = 0, dcnt_s = 0;
  int cycles = 0;
  logic [8:0] exp_q [$];

  always @(negedge clk) begin
    if (done_l) dcnt_l++;
    if (done_s) dcnt_s++;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void build(input bit sm, input int blk, input int pg, input int col,
                                input bit spare, input bit b16);
    int row, c;
    exp_q.delete();
    row = pg + blk * (sm ? 32 : 64);
    if (!sm) begin
      c = col + (spare ? 2048 : 0);
      if (b16) c = c >> 1;
      exp_q.push_back({1'b1, 8'h00});
      exp_q.push_back({1'b0, 8'(c & 255)});
      exp_q.push_back({1'b0, 8'((c >> 8) & 255)});
      exp_q.push_back({1'b0, 8'(row & 255)});
      exp_q.push_back({1'b0, 8'((row >> 8) & 255)});
      exp_q.push_back({1'b0, 8'((row >> 16) & 15)});
      exp_q.push_back({1'b1, 8'h30});
    end else begin
      exp_q.push_back({1'b1, spare ? 8'h50 : 8'h00});
      exp_q.push_back({1'b0, 8'(col & 255)});
      exp_q.push_back({1'b0, 8'(row & 255)});
      exp_q.push_back({1'b0, 8'((row >> 8) & 255)});
    end
  endfunction

  function automatic int ncap(input bit sm);
    return sm ? mon_s.n_cap : mon_l.n_cap;
  endfunction

  task automatic set_rb(input bit sm, input bit v);
    if (sm) rb_s = v; else rb_l = v;
  endtask

  task automatic start_req(input bit sm, input int blk, input int pg, input int col,
                           input bit spare, input bit b16);
    @(negedge clk);
    req_block = 12'(blk); req_page = 6'(pg); req_col = 11'(col);
    req_spare = spare; bus16 = b16;
    set_rb(sm, 1'b0);
    if (sm) begin req_valid_s = 1; clr_s = 1; end else begin req_valid_l = 1; clr_l = 1; end
    @(negedge clk);
    req_valid_s = 0; req_valid_l = 0; clr_s = 0; clr_l = 0;
  endtask

  task automatic do_seq(input bit sm, input int blk, input int pg, input int col,
                        input bit spare, input bit b16, input bit inject,
                        input bit hang_post, input string tag);
    int d0;
    bit wl, bz, er;
    build(sm, blk, pg, col, spare, b16);
    start_req(sm, blk, pg, col, spare, b16);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (inject && i == 1) begin
        req_block = 12'(blk + 5); req_page = 6'(pg ^ 1);
        if (sm) req_valid_s = 1; else req_valid_l = 1;
      end else begin
        req_valid_s = 0; req_valid_l = 0;
      end
    end
    #1;
    wl = sm ? we_s : we_l;
    chk(ncap(sm) == 0 && wl, "R2", "latch before ready", ncap(sm), 0);
    set_rb(sm, 1'b1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (ncap(sm) >= exp_q.size()) break;
    end
    set_rb(sm, 1'b0);
    d0 = sm ? dcnt_s : dcnt_l;
    if (hang_post) begin
      repeat (TMO + 6) @(negedge clk);
      #1;
      er = sm ? err_s : err_l; bz = sm ? busy_s : busy_l;
      chk(er && !bz, "R9", "post-wait timeout err/busy", {er, bz}, 2);
      chk((sm ? dcnt_s : dcnt_l) == d0, "R9", "done after timeout", (sm ? dcnt_s : dcnt_l) - d0, 0);
      set_rb(sm, 1'b1);
      repeat (4) @(negedge clk);
      return;
    end
    repeat (8) @(negedge clk);
    #1;
    bz = sm ? busy_s : busy_l;
    chk((sm ? dcnt_s : dcnt_l) == d0 && bz, "R2", "done while device busy", (sm ? dcnt_s : dcnt_l) - d0, 0);
    set_rb(sm, 1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if ((sm ? dcnt_s : dcnt_l) != d0) break;
    end
    @(negedge clk); #1;
    chk((sm ? dcnt_s : dcnt_l) == d0 + 1, "R2", "done pulse count", (sm ? dcnt_s : dcnt_l) - d0, 1);
    bz = sm ? busy_s : busy_l;
    chk(!bz, "R2", "busy after done", bz, 0);
    er = sm ? err_s : err_l;
    chk(!er, "R9", "err cleared by new request", er, 0);
    chk(ncap(sm) == exp_q.size(), tag, "latch cycle count", ncap(sm), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < ncap(sm); i++) begin
      logic [7:0] b;
      logic c, a;
      b = sm ? mon_s.cap_b[i] : mon_l.cap_b[i];
      c = sm ? mon_s.cap_c[i] : mon_l.cap_c[i];
      a = sm ? mon_s.cap_a[i] : mon_l.cap_a[i];
      chk(b == exp_q[i][7:0], tag, $sformatf("byte %0d", i), b, exp_q[i][7:0]);
      chk(c == exp_q[i][8] && a == !exp_q[i][8], "R3",
          $sformatf("cle/ale kind item %0d", i), {c, a}, {exp_q[i][8], !exp_q[i][8]});
    end
    chk((sm ? mon_s.n_bad : mon_l.n_bad) == 0, "R3", "strobe width/hold violations",
        sm ? mon_s.n_bad : mon_l.n_bad, 0);
  endtask

  task automatic do_pre_timeout(input bit sm);
    int d0;
    bit er, bz;
    d0 = sm ? dcnt_s : dcnt_l;
    start_req(sm, 7, 3, 1, 0, 0);
    repeat (TMO - 4) @(negedge clk);
    #1;
    er = sm ? err_s : err_l;
    chk(!er, "R9", "early timeout", er, 0);
    repeat (8) @(negedge clk);
    #1;
    er = sm ? err_s : err_l; bz = sm ? busy_s : busy_l;
    chk(er && !bz, "R9", "pre-wait timeout err/busy", {er, bz}, 2);
    chk(ncap(sm) == 0 && (sm ? dcnt_s : dcnt_l) == d0, "R9", "activity after timeout", ncap(sm), 0);
    set_rb(sm, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(!busy_l && !done_l && !err_l && !cle_l && !ale_l && we_l && io_l == 0, "R11",
        "large reset state", {busy_l, done_l, err_l, cle_l, ale_l, we_l}, 6'b000001);
    chk(!busy_s && !done_s && !err_s && !cle_s && !ale_s && we_s && io_s == 0, "R11",
        "small reset state", {busy_s, done_s, err_s, cle_s, ale_s, we_s}, 6'b000001);
    @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);

    do_seq(0, 5, 9, 300, 0, 0, 0, 0, "R4 R1");
    do_seq(0, 4000, 63, 2047, 0, 0, 0, 0, "R5 R1");
    do_seq(0, 12, 1, 16, 1, 0, 0, 0, "R6");
    do_seq(0, 12, 1, 16, 1, 1, 0, 0, "R7");
    do_seq(0, 33, 2, 1001, 0, 1, 0, 0, "R7");
    do_seq(0, 100, 7, 64, 0, 0, 1, 0, "R10");
    do_seq(1, 9, 17, 200, 0, 0, 0, 0, "R8 R1");
    do_seq(1, 4095, 31, 45, 1, 0, 0, 0, "R8");
    do_seq(1, 77, 4, 300, 0, 1, 0, 0, "R8");
    do_seq(1, 50, 3, 12, 0, 0, 1, 0, "R10");
    do_pre_timeout(1);
    do_seq(1, 2, 2, 2, 0, 0, 0, 0, "R8");
    do_pre_timeout(0);
    do_seq(0, 3, 3, 3, 0, 0, 0, 1, "R9");
    do_seq(0, 6, 6, 6, 1, 0, 0, 0, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule